// File: doc/BRIEF.md
# GPIO Edge-Event and Pin-Task Unit

This unit holds a small set of independent slots. Each slot is tied to one GPIO pin of a shared pin bank. A slot in watch mode samples its pin through a two-stage synchronizer. It turns one chosen transition kind into a single-cycle event pulse: rising, falling or any change. A slot in drive mode owns its pin. It changes the pin level in response to set, clear and toggle task strobes, and starts from a configured initial level. The whole unit runs on the interconnect clock.

Another peripheral may already hold a pin. The ownership input marks such pins, and the unit will not attach to them, not even to observe. A configuration write that names an owned pin is refused. The slot is then left disabled and an error flag pulses for one cycle. If a pin becomes owned while a slot holds it, the slot lets go. A drive claim on a pin that another slot of this unit already drives is refused in the same way.

Each slot is a three-state machine with states IDLE, WATCH and DRIVE. It has these named transitions:
- ACCEPT_WATCH: an accepted watch-mode write, from any state to WATCH.
- ACCEPT_DRIVE: an accepted drive-mode write, from any state to DRIVE.
- REJECT: a refused write, from any state to IDLE.
- SWITCH_OFF: a write with the off mode, from any state to IDLE.
- EVICT: the held pin becomes owned, from WATCH or DRIVE to IDLE.
- HOLD: no write and no eviction, so the state is kept.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every slot is IDLE: `pin_oe`, `evt` and `cfg_err` are all zero.
- R2: A WATCH slot with edge code 2'b00 (rising) pulses its `evt` bit for exactly one cycle. The pulse is seen in the third cycle after the pin rises, counted as two synchronizer stages plus the event register. A falling pin gives no event.
- R3: With edge code 2'b01 (falling), only a high-to-low pin change produces the one-cycle event.
- R4: With edge code 2'b10 (any change), both rising and falling pin changes each produce one event.
- R5: A write with mode 2'b10 (drive) to a free pin sets `pin_oe` for that pin in the cycle after the write. `pin_out` then equals `cfg_init`.
- R6: In DRIVE, a clear task drives the pin low, a set task drives it high, and a toggle task inverts it. Each change takes effect one cycle after the strobe.
- R7: Clear wins over set when both arrive together. Toggle acts only when neither set nor clear is active.
- R8: A watch (2'b01) or drive write that names a pin marked in `pin_owned` is refused. `cfg_err` pulses for one cycle, the slot is left IDLE, and it neither drives the pin nor reports events.
- R9: A drive write that names a pin already driven by another slot is refused with a `cfg_err` pulse. The existing driver keeps the pin and the refused slot drives nothing.
- R10: If `pin_owned` rises for the pin a slot holds, the slot moves to IDLE in the next cycle. It does not reattach when the ownership is withdrawn.
- R11: Task strobes to a slot that is not in DRIVE have no effect on any pin.
- R12: A write with mode 2'b00 (or 2'b11) turns the slot off. Its pin is released in the next cycle.
- R13: Entering WATCH on a pin that is already high causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NUM_PINS | Raw pin levels from the pad bank |
| pin_owned | input | NUM_PINS | Pins held by other peripherals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot addressed by the write |
| cfg_mode | input | 2 | 00 off, 01 watch, 10 drive, 11 off |
| cfg_pin | input | PIN_W | Pin number to attach |
| cfg_edge | input | 2 | 00 rising, 01 falling, 10/11 any change |
| cfg_init | input | 1 | Pin level on entering drive mode |
| task_set | input | NUM_SLOTS | Per-slot set strobe |
| task_clr | input | NUM_SLOTS | Per-slot clear strobe |
| task_tgl | input | NUM_SLOTS | Per-slot toggle strobe |
| evt | output | NUM_SLOTS | Per-slot one-cycle event pulse |
| pin_out | output | NUM_PINS | Driven pin levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| cfg_err | output | 1 | One-cycle pulse on a refused write |

## Verification
In a DRIVE slot, set, clear and toggle strobes can land in the same cycle. The bench raises them in pairs during a single clock and then reads the pin level on the following cycle; clear must win, and set must win over toggle. A second collision happens between a configuration write and a pin already held elsewhere. That holder is either the ownership input or a sibling slot. The bench checks the error pulse, confirms the original driver's level is unchanged, and confirms that strobing the refused slot moves nothing.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IN   = 2'b01,
        MODE_OUT  = 2'b10,
        MODE_RSVD = 2'b11
    } slot_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_ANY  = 2'b10,
        EDGE_ANY2 = 2'b11
    } edge_kind_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'b00,
        SLOT_WATCH = 2'b01,
        SLOT_DRIVE = 2'b10
    } slot_state_e;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_slot.sv
module gpio_evt_slot
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_hit,
    input  logic [1:0]          cfg_mode,
    input  logic [PIN_W-1:0]    cfg_pin,
    input  logic [1:0]          cfg_edge,
    input  logic                cfg_init,
    input  logic                owned_hit,
    input  logic                peer_hit,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] pin_owned,
    input  logic                task_set,
    input  logic                task_clr,
    input  logic                task_tgl,
    output logic                evt,
    output logic                drive_en,
    output logic [PIN_W-1:0]    drive_pin,
    output logic                drive_level,
    output logic                reject
);

    slot_state_e      state_q, state_d;
    edge_kind_e       edge_q;
    logic [PIN_W-1:0] pin_q;
    logic             level_q, prev_q, evt_q, err_q;

    slot_mode_e mode_w;
    logic       want_in, want_out, cfg_refuse, held_lost, cur_lvl, edge_seen;

    // write decode and refusal rules
    always_comb begin
        mode_w     = slot_mode_e'(cfg_mode);
        want_in    = cfg_hit && (mode_w == MODE_IN);
        want_out   = cfg_hit && (mode_w == MODE_OUT);
        cfg_refuse = (want_in && owned_hit) || (want_out && (owned_hit || peer_hit));
        held_lost  = (state_q != SLOT_IDLE) && pin_owned[pin_q];
    end

    // next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        if (cfg_hit) begin
            if (want_in && !cfg_refuse)       state_d = SLOT_WATCH;  // ACCEPT_WATCH
            else if (want_out && !cfg_refuse) state_d = SLOT_DRIVE;  // ACCEPT_DRIVE
            else                              state_d = SLOT_IDLE;   // REJECT / SWITCH_OFF
        end else begin
            unique case (state_q)
                SLOT_IDLE:  state_d = SLOT_IDLE;                          // HOLD
                SLOT_WATCH: state_d = held_lost ? SLOT_IDLE : SLOT_WATCH; // EVICT / HOLD
                SLOT_DRIVE: state_d = held_lost ? SLOT_IDLE : SLOT_DRIVE; // EVICT / HOLD
                default:    state_d = SLOT_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // edge detector on the selected synchronized pin
    always_comb begin
        cur_lvl = pin_sync[pin_q];
        unique case (edge_q)
            EDGE_RISE: edge_seen = cur_lvl && !prev_q;
            EDGE_FALL: edge_seen = !cur_lvl && prev_q;
            EDGE_ANY,
            EDGE_ANY2: edge_seen = cur_lvl != prev_q;
            default:   edge_seen = 1'b0;
        endcase
    end

    // slot datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= '0;
            edge_q  <= EDGE_RISE;
            prev_q  <= 1'b0;
            level_q <= 1'b0;
            evt_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= cfg_refuse;
            evt_q <= !cfg_hit && (state_q == SLOT_WATCH) && (state_d == SLOT_WATCH) && edge_seen;
            if (cfg_hit && (state_d != SLOT_IDLE)) begin
                pin_q  <= cfg_pin;
                edge_q <= edge_kind_e'(cfg_edge);
                prev_q <= pin_sync[cfg_pin];
            end else begin
                prev_q <= cur_lvl;
            end
            if (cfg_hit && (state_d == SLOT_DRIVE)) begin
                level_q <= cfg_init;
            end else if ((state_q == SLOT_DRIVE) && (state_d == SLOT_DRIVE)) begin
                if (task_clr)      level_q <= 1'b0;
                else if (task_set) level_q <= 1'b1;
                else if (task_tgl) level_q <= !level_q;
            end
        end
    end

    // output process
    always_comb begin
        evt         = evt_q;
        reject      = err_q;
        drive_en    = (state_q == SLOT_DRIVE);
        drive_pin   = pin_q;
        drive_level = level_q;
    end

    // R2: an event is only reported by a slot that was watching
    p_evt_from_watch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(state_q) == SLOT_WATCH);

    // R7: clear wins whenever the slot stays in DRIVE
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_DRIVE && state_d == SLOT_DRIVE && !cfg_hit && task_clr) |=> !level_q);

    // R7: set wins over toggle
    p_set_over_tgl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_DRIVE && state_d == SLOT_DRIVE && !cfg_hit && task_set && !task_clr) |=> level_q);

    // R6: a lone toggle inverts the level
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_DRIVE && state_d == SLOT_DRIVE && !cfg_hit && task_tgl && !task_set && !task_clr)
        |=> level_q != $past(level_q));

    // R8: a refused write leaves the slot idle
    p_refused_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> state_q == SLOT_IDLE);

    // R10: an ownership conflict evicts the slot
    p_evict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SLOT_IDLE && !cfg_hit && pin_owned[pin_q]) |=> state_q == SLOT_IDLE);

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_PINS  = 8,
    parameter int SYNC_STG  = 2,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic [NUM_PINS-1:0]  pin_owned,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [1:0]           cfg_mode,
    input  logic [PIN_W-1:0]     cfg_pin,
    input  logic [1:0]           cfg_edge,
    input  logic                 cfg_init,
    input  logic [NUM_SLOTS-1:0] task_set,
    input  logic [NUM_SLOTS-1:0] task_clr,
    input  logic [NUM_SLOTS-1:0] task_tgl,
    output logic [NUM_SLOTS-1:0] evt,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic                 cfg_err
);

    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_SLOTS-1:0] drv_en, drv_lvl, slot_rej, peer_hit, slot_hit;
    logic [PIN_W-1:0]     drv_pin [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] claim_col [NUM_PINS];
    logic                 pin_ok, owned_hit;

    gpio_evt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // target decode and claim conflicts
    always_comb begin
        pin_ok    = {1'b0, cfg_pin} < (PIN_W+1)'(NUM_PINS);
        owned_hit = !pin_ok || pin_owned[cfg_pin];
        for (int s = 0; s < NUM_SLOTS; s++) begin
            slot_hit[s] = cfg_we && (cfg_slot == SLOT_W'(s));
            peer_hit[s] = 1'b0;
            for (int t = 0; t < NUM_SLOTS; t++) begin
                if (t != s && drv_en[t] && drv_pin[t] == cfg_pin) peer_hit[s] = 1'b1;
            end
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            gpio_evt_slot #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .cfg_hit     (slot_hit[s]),
                .cfg_mode    (cfg_mode),
                .cfg_pin     (cfg_pin),
                .cfg_edge    (cfg_edge),
                .cfg_init    (cfg_init),
                .owned_hit   (owned_hit),
                .peer_hit    (peer_hit[s]),
                .pin_sync    (pin_sync),
                .pin_owned   (pin_owned),
                .task_set    (task_set[s]),
                .task_clr    (task_clr[s]),
                .task_tgl    (task_tgl[s]),
                .evt         (evt[s]),
                .drive_en    (drv_en[s]),
                .drive_pin   (drv_pin[s]),
                .drive_level (drv_lvl[s]),
                .reject      (slot_rej[s])
            );
        end
    endgenerate

    // merge per-slot drivers onto the pin bank
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            pin_oe[p]  = 1'b0;
            pin_out[p] = 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                claim_col[p][s] = drv_en[s] && (drv_pin[s] == PIN_W'(p));
                if (claim_col[p][s]) begin
                    pin_oe[p]  = 1'b1;
                    pin_out[p] = pin_out[p] | drv_lvl[s];
                end
            end
        end
        cfg_err = |slot_rej;
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
            // R9: at most one slot drives a pin
            p_single_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(claim_col[p]));
            // R8: a pin owned elsewhere is never driven one cycle later
            p_owned_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_owned[p] && $past(pin_owned[p])) |-> !pin_oe[p]);
        end
    endgenerate

endmodule

// File: tb/gpio_evt_unit_test.sv
module gpio_evt_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, pin_owned = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_slot = '0, cfg_mode = '0, cfg_edge = '0;
    logic [2:0] cfg_pin = '0;
    logic       cfg_init = 1'b0;
    logic [3:0] task_set = '0, task_clr = '0, task_tgl = '0;
    logic [3:0] evt;
    logic [7:0] pin_out, pin_oe;
    logic       cfg_err;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_evt_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_owned(pin_owned),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode), .cfg_pin(cfg_pin),
        .cfg_edge(cfg_edge), .cfg_init(cfg_init), .task_set(task_set), .task_clr(task_clr),
        .task_tgl(task_tgl), .evt(evt), .pin_out(pin_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(int slot, int mode, int pin, int edg, int init);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_mode = 2'(mode);
        cfg_pin = 3'(pin); cfg_edge = 2'(edg); cfg_init = 1'(init);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(int slot, bit s, bit c, bit t);
        @(negedge clk);
        task_set[slot] = s; task_clr[slot] = c; task_tgl[slot] = t;
        @(negedge clk);
        task_set = '0; task_clr = '0; task_tgl = '0;
    endtask

    // counts events over six cycles after a pin change made at a falling clock edge
    task automatic watch(int idx, int exp_at, string req);
        int hits = 0;
        int at = -1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (evt[idx]) begin hits++; at = i; end
        end
        check(req, hits, (exp_at > 0) ? 1 : 0);
        if (exp_at > 0) check(req, at, exp_at);
    endtask

    task automatic t_reset;
        check("R1 pin_oe", int'(pin_oe), 0);
        check("R1 evt", int'(evt), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_rise;
        cfg(0, 1, 2, 0, 0);
        @(negedge clk); pin_in[2] = 1'b1;
        watch(0, 3, "R2 rise");
        pin_in[2] = 1'b0;
        watch(0, 0, "R2 fall ignored");
    endtask

    task automatic t_fall;
        cfg(1, 1, 3, 1, 0);
        @(negedge clk); pin_in[3] = 1'b1;
        watch(1, 0, "R3 rise ignored");
        pin_in[3] = 1'b0;
        watch(1, 3, "R3 fall");
    endtask

    task automatic t_any;
        cfg(2, 1, 4, 2, 0);
        @(negedge clk); pin_in[4] = 1'b1;
        watch(2, 3, "R4 rise");
        pin_in[4] = 1'b0;
        watch(2, 3, "R4 fall");
    endtask

    task automatic t_no_spurious;
        @(negedge clk); pin_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        cfg(3, 1, 5, 0, 0);
        watch(3, 0, "R13 high at entry");
    endtask

    task automatic t_ignored;
        strobe(3, 1'b1, 1'b0, 1'b1);
        check("R11 oe after tasks", int'(pin_oe), 0);
        strobe(3, 1'b0, 1'b0, 1'b1);
        check("R11 oe after toggle", int'(pin_oe), 0);
    endtask

    task automatic t_output;
        cfg(0, 2, 6, 0, 1);
        check("R5 oe", int'(pin_oe[6]), 1);
        check("R5 level", int'(pin_out[6]), 1);
        check("R5 no err", int'(cfg_err), 0);
    endtask

    task automatic t_tasks;
        strobe(0, 1'b0, 1'b1, 1'b0); check("R6 clear", int'(pin_out[6]), 0);
        strobe(0, 1'b1, 1'b0, 1'b0); check("R6 set", int'(pin_out[6]), 1);
        strobe(0, 1'b0, 1'b0, 1'b1); check("R6 toggle", int'(pin_out[6]), 0);
        strobe(0, 1'b0, 1'b0, 1'b1); check("R6 toggle back", int'(pin_out[6]), 1);
    endtask

    task automatic t_priority;
        strobe(0, 1'b1, 1'b1, 1'b0); check("R7 set+clr", int'(pin_out[6]), 0);
        strobe(0, 1'b1, 1'b0, 1'b1); check("R7 set+tgl", int'(pin_out[6]), 1);
        strobe(0, 1'b0, 1'b1, 1'b1); check("R7 clr+tgl", int'(pin_out[6]), 0);
        strobe(0, 1'b1, 1'b1, 1'b1); check("R7 all three", int'(pin_out[6]), 0);
    endtask

    task automatic t_reject_owned;
        @(negedge clk); pin_owned[7] = 1'b1; pin_owned[1] = 1'b1;
        cfg(1, 2, 7, 0, 1);
        check("R8 err pulse", int'(cfg_err), 1);
        check("R8 no oe", int'(pin_oe[7]), 0);
        @(negedge clk);
        check("R8 err one cycle", int'(cfg_err), 0);
        cfg(1, 1, 1, 2, 0);
        check("R8 watch refused", int'(cfg_err), 1);
        @(negedge clk); pin_in[1] = 1'b1;
        watch(1, 0, "R8 owned pin silent");
        pin_in[3] = 1'b1;
        watch(1, 0, "R8 slot left idle");
        pin_owned[1] = 1'b0; pin_owned[7] = 1'b0;
    endtask

    task automatic t_peer;
        cfg(2, 2, 6, 0, 1);
        check("R9 err", int'(cfg_err), 1);
        check("R9 keeps oe", int'(pin_oe[6]), 1);
        check("R9 keeps level", int'(pin_out[6]), 0);
        strobe(2, 1'b1, 1'b0, 1'b0);
        check("R9 refused slot inert", int'(pin_out[6]), 0);
    endtask

    task automatic t_evict;
        @(negedge clk); pin_owned[6] = 1'b1;
        @(negedge clk);
        check("R10 evicted", int'(pin_oe[6]), 0);
        pin_owned[6] = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 no reattach", int'(pin_oe[6]), 0);
    endtask

    task automatic t_disable;
        cfg(0, 2, 0, 0, 1);
        check("R12 attached", int'(pin_oe[0]), 1);
        cfg(0, 0, 0, 0, 0);
        check("R12 released", int'(pin_oe[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_rise();
        t_fall();
        t_any();
        t_no_spurious();
        t_ignored();
        t_output();
        t_tasks();
        t_priority();
        t_reject_owned();
        t_peer();
        t_evict();
        t_disable();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule